// File: doc/BRIEF.md
# Twin-Port Integer ALU Dispatcher with Width-Dependent Latency

This block feeds two identical integer execution ports from one operation stream. Each port owns an ALU and a single result bus. An operation's latency depends on its width and class. 32-bit work and 64-bit bitwise logic finish in one cycle. 64-bit add, subtract, shift and rotate take two cycles.

The long path is pipelined, so a port can start a new long operation every cycle. A short operation that starts on a port one cycle after a long one would land on that port's result bus in the same cycle. The dispatcher therefore sends that short operation to the twin port.

Upstream logic offers one operation per cycle with a valid/ready handshake. Each port reports a result strobe carrying the operation's tag and data in the cycle the result appears.

Top module: `alu_twin_dispatch`

## Requirements
- R1: A 32-bit operation of any class, accepted at a clock edge, presents its result one cycle later: its port's result strobe is high after the next edge.
- R2: A 64-bit add (op 0), subtract (op 1), shift left (op 2), logical shift right (op 3), rotate left (op 4) or rotate right (op 5) presents its result two cycles after acceptance.
- R3: A 64-bit AND (op 6) or XOR (op 7) presents its result one cycle after acceptance.
- R4: Steering works as follows. Every two-cycle operation is issued on port 0. A one-cycle operation also goes to port 0, unless port 0 accepted a two-cycle operation in the previous cycle; in that case it goes to port 1. A result strobe is never raised without a matching accepted operation.
- R5: Two-cycle operations accepted on consecutive cycles each produce a result, on consecutive cycles, with no bubble and no lost result.
- R6: Results follow the op encoding (0 add, 1 subtract, 2 shift left, 3 logical shift right, 4 rotate left, 5 rotate right, 6 AND, 7 XOR). In_wide=1 selects 64 bits. For 32-bit operations, only bits 31:0 of the operands are used and the result is zero-extended to 64 bits.
- R7: The shift and rotate amount is in_b[4:0] for 32-bit operations and in_b[5:0] for 64-bit operations. Higher bits of in_b are ignored.
- R8: in_ready is low while reset is asserted. Outside reset it is high, because one operation per cycle can block a one-cycle operation on at most one port.
- R9: A synchronous active-high reset clears both result strobes and discards any two-cycle operation still in flight.
- R10: Each result strobe carries the tag of the operation whose result it presents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 3 | Operation code |
| in_wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand / shift amount |
| in_tag | input | TAG_W | Operation tag |
| p0_valid | output | 1 | Port 0 result strobe |
| p0_tag | output | TAG_W | Port 0 result tag |
| p0_data | output | 64 | Port 0 result |
| p1_valid | output | 1 | Port 1 result strobe |
| p1_tag | output | TAG_W | Port 1 result tag |
| p1_data | output | 64 | Port 1 result |

## Verification
The bench sweeps every opcode at both widths over operand values that hit carries, borrows, sign bits and shift amounts of 0, 31, 32, 63 and masked overflow. Operations are issued back to back, so long-then-short pairs arise constantly.

A design that lets a short operation follow a long one on port 0 drops or corrupts a result and shows a tag mismatch. A design that inserts a bubble between consecutive long operations loses results and fails the result count. A reset that does not flush the long stage releases a stale result after reset. Wrong masking or a missing zero extension shows up directly in the 32-bit rotate and shift data.

// File: rtl/alu_twin_dispatch.sv
`timescale 1ns/1ps
module alu_twin_dispatch #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_op,
  input  logic             in_wide,
  input  logic [63:0]      in_a,
  input  logic [63:0]      in_b,
  input  logic [TAG_W-1:0] in_tag,
  output logic             p0_valid,
  output logic [TAG_W-1:0] p0_tag,
  output logic [63:0]      p0_data,
  output logic             p1_valid,
  output logic [TAG_W-1:0] p1_tag,
  output logic [63:0]      p1_data
);
  localparam int DW = 64;
  localparam int HW = DW / 2;
  localparam int NP = 2;

  logic [NP-1:0]    mid_v, out_v, tgt;
  logic [TAG_W-1:0] mid_tag [NP];
  logic [TAG_W-1:0] out_tag [NP];
  logic [DW-1:0]    mid_d [NP];
  logic [DW-1:0]    out_d [NP];
  logic             is_long, acc;
  logic [5:0]       sh;
  logic [2*DW-1:0]  w2;
  logic [DW-1:0]    n2, res;
  logic [HW-1:0]    a32, b32, r32;

  assign is_long  = in_wide && (in_op < 3'd6);
  assign in_ready = !rst && (is_long || !(&mid_v));
  assign acc      = in_valid && in_ready;
  assign tgt      = (!is_long && mid_v[0]) ? 2'b10 : 2'b01;

  always_comb begin
    a32 = in_a[HW-1:0];
    b32 = in_b[HW-1:0];
    sh  = in_wide ? in_b[5:0] : {1'b0, in_b[4:0]};
    w2  = '0;
    n2  = '0;
    r32 = '0;
    res = '0;
    if (in_wide) begin
      case (in_op)
        3'd0: res = in_a + in_b;
        3'd1: res = in_a - in_b;
        3'd2: res = in_a << sh;
        3'd3: res = in_a >> sh;
        3'd4: begin w2 = {in_a, in_a} << sh; res = w2[2*DW-1:DW]; end
        3'd5: begin w2 = {in_a, in_a} >> sh; res = w2[DW-1:0]; end
        3'd6: res = in_a & in_b;
        default: res = in_a ^ in_b;
      endcase
    end else begin
      case (in_op)
        3'd0: r32 = a32 + b32;
        3'd1: r32 = a32 - b32;
        3'd2: r32 = a32 << sh;
        3'd3: r32 = a32 >> sh;
        3'd4: begin n2 = {a32, a32} << sh; r32 = n2[DW-1:HW]; end
        3'd5: begin n2 = {a32, a32} >> sh; r32 = n2[HW-1:0]; end
        3'd6: r32 = a32 & b32;
        default: r32 = a32 ^ b32;
      endcase
      res = {{HW{1'b0}}, r32};
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (rst) begin
        mid_v[p] <= 1'b0;
        out_v[p] <= 1'b0;
      end else begin
        mid_v[p] <= acc && is_long && tgt[p];
        out_v[p] <= mid_v[p] || (acc && !is_long && tgt[p]);
      end
      mid_tag[p] <= in_tag;
      mid_d[p]   <= res;
      out_tag[p] <= mid_v[p] ? mid_tag[p] : in_tag;
      out_d[p]   <= mid_v[p] ? mid_d[p] : res;
    end
  end

  assign p0_valid = out_v[0];
  assign p0_tag   = out_tag[0];
  assign p0_data  = out_d[0];
  assign p1_valid = out_v[1];
  assign p1_tag   = out_tag[1];
  assign p1_data  = out_d[1];
endmodule

module alu_twin_dispatch_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_op,
  input logic             in_wide,
  input logic [TAG_W-1:0] in_tag,
  input logic             p0_valid,
  input logic [TAG_W-1:0] p0_tag,
  input logic             p1_valid,
  input logic [TAG_W-1:0] p1_tag
);
  logic acc_long, acc_short;
  assign acc_long  = in_valid && in_ready && in_wide && (in_op < 3'd6);
  assign acc_short = in_valid && in_ready && !(in_wide && (in_op < 3'd6));

  assert_short_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    acc_short |=> ((p0_valid && p0_tag == $past(in_tag)) || (p1_valid && p1_tag == $past(in_tag))));

  assert_long_two_cycles_R2: assert property (@(posedge clk) disable iff (rst)
    acc_long |=> ##1 (p0_valid && p0_tag == $past(in_tag, 2)));

  assert_port1_after_long_R4: assert property (@(posedge clk) disable iff (rst)
    p1_valid |-> $past(acc_long, 2));

  assert_ready_out_of_reset_R8: assert property (@(posedge clk) disable iff (rst)
    in_ready);

  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!p0_valid && !p1_valid));
endmodule

bind alu_twin_dispatch alu_twin_dispatch_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_wide(in_wide), .in_tag(in_tag),
  .p0_valid(p0_valid), .p0_tag(p0_tag), .p1_valid(p1_valid), .p1_tag(p1_tag)
);

// File: tb/alu_twin_dispatch_tb.sv
`timescale 1ns/1ps
module alu_twin_dispatch_tb;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [2:0]    in_op;
  logic          in_wide;
  logic [63:0]   in_a, in_b;
  logic [TW-1:0] in_tag;
  logic          p0_valid, p1_valid;
  logic [TW-1:0] p0_tag, p1_tag;
  logic [63:0]   p0_data, p1_data;

  int n_chk = 0, n_fail = 0, cyc = 0, issued = 0, got = 0;
  bit prev_long = 0, done = 0;
  logic [TW-1:0] tag_ctr = '0;
  bit          ev  [2][4];
  logic [TW-1:0] et [2][4];
  logic [63:0] ed  [2][4];
  string       elat[2][4];
  string       edat[2][4];

  always #2.5 clk = ~clk;

  alu_twin_dispatch #(.TAG_W(TW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_wide(in_wide), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
    .p0_valid(p0_valid), .p0_tag(p0_tag), .p0_data(p0_data),
    .p1_valid(p1_valid), .p1_tag(p1_tag), .p1_data(p1_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [2:0] op, input bit wide,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] m, x, y, r;
    int w, s;
    w = wide ? 64 : 32;
    m = wide ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    x = a & m;
    y = b & m;
    s = int'(b % 64'(w));
    case (op)
      3'd0: r = x + y;
      3'd1: r = x - y;
      3'd2: r = x << s;
      3'd3: r = x >> s;
      3'd4: r = (x << s) | ((s == 0) ? 64'd0 : (x >> (w - s)));
      3'd5: r = (x >> s) | ((s == 0) ? 64'd0 : (x << (w - s)));
      3'd6: r = x & y;
      default: r = x ^ y;
    endcase
    return r & m;
  endfunction

  task automatic chk_port(input int p, input int s);
    logic v;
    logic [TW-1:0] t;
    logic [63:0] d;
    v = (p == 1) ? p1_valid : p0_valid;
    t = (p == 1) ? p1_tag : p0_tag;
    d = (p == 1) ? p1_data : p0_data;
    // R4: no strobe without a matching accepted operation on this port
    check(v == ev[p][s], ev[p][s] ? elat[p][s] : "R4", $sformatf("port%0d valid", p),
          64'(v), 64'(ev[p][s]));
    if (v && ev[p][s]) begin
      check(t == et[p][s], "R10", $sformatf("port%0d tag", p), 64'(t), 64'(et[p][s]));
      check(d == ed[p][s], edat[p][s], $sformatf("port%0d data", p), d, ed[p][s]);
      if (t == et[p][s] && d == ed[p][s]) got++;
    end
    ev[p][s] = 0;
  endtask

  task automatic step(input bit v, input logic [2:0] op, input bit wide,
                      input logic [63:0] a, input logic [63:0] b);
    int s, ds, p;
    bit lng;
    s = cyc % 4;
    chk_port(0, s);
    chk_port(1, s);
    in_valid = v; in_op = op; in_wide = wide; in_a = a; in_b = b; in_tag = tag_ctr;
    #1;
    if (v) begin
      check(in_ready == 1'b1, "R8", "ready out of reset", 64'(in_ready), 64'd1);
      lng = wide && (op < 3'd6);
      p   = (!lng && prev_long) ? 1 : 0;
      ds  = (cyc + (lng ? 2 : 1)) % 4;
      ev[p][ds]   = 1;
      et[p][ds]   = tag_ctr;
      ed[p][ds]   = model(op, wide, a, b);
      elat[p][ds] = lng ? "R2" : (wide ? "R3" : "R1");
      edat[p][ds] = (op >= 3'd2 && op <= 3'd5) ? "R7" : "R6";
      prev_long = lng;
      issued++;
      tag_ctr++;
    end else begin
      prev_long = 0;
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic clear_model();
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 4; k++) ev[p][k] = 0;
    prev_long = 0;
  endtask

  initial begin
    logic [63:0] av [4];
    logic [63:0] bv [6];
    av[0] = 64'd0;                   av[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    av[2] = 64'h8000_0000_FFFF_FFFF; av[3] = 64'h0123_4567_89AB_CDEF;
    bv[0] = 64'd0;  bv[1] = 64'd1;  bv[2] = 64'd31; bv[3] = 64'd32;
    bv[4] = 64'd63; bv[5] = 64'hFFFF_FFFF_FFFF_FFC5;
    clear_model();
    rst = 1'b1; in_valid = 1'b0; in_op = '0; in_wide = 1'b0;
    in_a = '0; in_b = '0; in_tag = '0;
    repeat (3) @(negedge clk);
    // R9, R8: reset state
    check(!p0_valid && !p1_valid, "R9", "strobes in reset", 64'({p1_valid, p0_valid}), 64'd0);
    in_valid = 1'b1; #1;
    check(in_ready == 1'b0, "R8", "ready in reset", 64'(in_ready), 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;

    // Sweep every op at both widths over operand corners (R1, R2, R3, R6, R7), back to back
    for (int op = 0; op < 8; op++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 6; j++)
            step(1'b1, 3'(op), w[0], av[i], bv[j]);
    repeat (3) step(1'b0, 3'd0, 1'b0, 64'd0, 64'd0);

    // R5 and R4: long burst then short ops steered to port 1
    for (int k = 0; k < 5; k++) step(1'b1, 3'd0, 1'b1, 64'(k) << 40, 64'd7);
    step(1'b1, 3'd6, 1'b1, 64'hF0F0, 64'hFF00);
    step(1'b1, 3'd0, 1'b0, 64'hFFFF_FFFF, 64'd1);
    step(1'b1, 3'd5, 1'b1, 64'h1, 64'd1);
    step(1'b1, 3'd4, 1'b0, 64'h8000_0001, 64'd33);
    repeat (3) step(1'b0, 3'd0, 1'b0, 64'd0, 64'd0);

    // Random mix with gaps
    for (int k = 0; k < 2000; k++)
      step(($urandom % 4) != 0, 3'($urandom % 8), 1'($urandom % 2),
           {$urandom, $urandom}, {$urandom, $urandom});
    repeat (3) step(1'b0, 3'd0, 1'b0, 64'd0, 64'd0);
    // R5: no result lost
    check(got == issued, "R5", "results delivered", 64'(got), 64'(issued));

    // R9: reset discards an in-flight long operation
    step(1'b1, 3'd1, 1'b1, 64'd9, 64'd3);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    check(!p0_valid && !p1_valid, "R9", "strobes after reset", 64'({p1_valid, p0_valid}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!p0_valid && !p1_valid, "R9", "no stale result", 64'({p1_valid, p0_valid}), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule